// File: doc/BRIEF.md
# Split-Mode Signed Multiplier

This block is a purely combinational two's-complement multiplier. It is built on a single array of partial products that has been rearranged so that signed operands need no sign-extension rows. A mode input chooses how that one array is used. With the mode low, the two 8-bit operands are multiplied as whole signed numbers into a signed 16-bit product. With the mode high, each operand is treated as two signed 4-bit nibbles. The low nibbles are multiplied together and the high nibbles are multiplied together, and the two signed 8-bit results are packed side by side in the 16-bit output.

The mode changes four things in the array. It changes which partial-product bits are complemented. It changes where the constant ones are injected. It forces to zero the bits that pair a low nibble with a high nibble. It changes which result bits are complemented after the final addition. A small decoder turns the mode into a handful of strobes. The datapath reads those strobes to shape the array and the final inversion. Because of this split, a caller that works on narrow signed samples gets two products per evaluation from the same adder tree.

Top module: `twin_bw_mul`

## Requirements
- R1: With `twin` = 0, `p` interpreted as a signed 16-bit number equals the signed product of `a` and `b`, each taken as a signed 8-bit number, for every operand pair.
- R2: With `twin` = 1, `p[7:0]` interpreted as a signed 8-bit number equals the signed product of `a[3:0]` and `b[3:0]`, each taken as a signed 4-bit number.
- R3: With `twin` = 1, `p[15:8]` interpreted as a signed 8-bit number equals the signed product of `a[7:4]` and `b[7:4]`, each taken as a signed 4-bit number.
- R4: With `twin` = 1, the high nibbles of the operands have no effect on `p[7:0]`, and the low nibbles have no effect on `p[15:8]`. No carry passes from the low product into the high product.
- R5: With `twin` = 0, the most negative operands give the largest result: -128 times -128 gives `p` = 16'h4000, and -128 times 127 gives 16'hC080.
- R6: With `twin` = 1, the nibble corner -8 times -8 gives 64 in each byte (`p` = 16'h4040), and -8 times 7 gives -56 in each byte (`p` = 16'hC8C8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Multiplicand: one signed byte, or two signed nibbles when twin is set |
| b | input | 8 | Multiplier: one signed byte, or two signed nibbles when twin is set |
| twin | input | 1 | 0: one 8x8 signed product; 1: two independent 4x4 signed products |
| p | output | 16 | Full signed product, or {high-nibble product, low-nibble product} |

## Verification
Both modes are swept over all 65,536 operand pairs, and each result is compared with a product computed arithmetically in the bench. The full sweep tells apart errors in the complemented bit sets and in the constant columns, because each of those errors only shows up when particular operand signs combine. A separate twin-mode pass holds the low nibbles fixed and cycles the high nibbles, and then does the reverse, so that a gating or carry leak between the two sub-products is reported as an isolation failure. The extreme negative operands are tried on their own, because those are the cases in which a wrong sign-bit inversion or a dropped constant changes the top result bit.

// File: rtl/twin_mul_pkg.sv
package twin_mul_pkg;

  // Strobes from the mode decoder to the array datapath
  typedef struct packed {
    logic gateCross;  // zero the partial products pairing a low nibble with a high nibble
    logic halfInv;    // complement the sign-boundary bits of each half-width sub-array
    logic fullInv;    // complement the sign-boundary bits of the full-width array
    logic halfConst;  // inject a one at the constant column of each sub-product
    logic fullConst;  // inject a one at the constant column of the full product
    logic midOutInv;  // complement the top bit of the lower result half as well
  } mulStrobes_t;

endpackage

// File: rtl/twin_mul_ctrl.sv
module twin_mul_ctrl
  import twin_mul_pkg::*;
(
  input  logic        twin,
  output mulStrobes_t strobes
);

  always_comb begin
    strobes           = '0;
    strobes.gateCross = twin;
    strobes.halfInv   = twin;
    strobes.halfConst = twin;
    strobes.midOutInv = twin;
    strobes.fullInv   = !twin;
    strobes.fullConst = !twin;
  end

  // one inversion scheme and one constant scheme are active at any time
  always_comb begin
    AST_ONE_SCHEME : assert ((strobes.halfInv ^ strobes.fullInv) &&
                             (strobes.halfConst ^ strobes.fullConst)); // R4
  end

endmodule

// File: rtl/twin_mul_pparray.sv
module twin_mul_pparray
  import twin_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]        opA,
  input  logic [W-1:0]        opB,
  input  mulStrobes_t         strobes,
  output logic [W-1:0][W-1:0] ppBits   // [row = opB bit][column = opA bit]
);

  localparam int H = W / 2;

  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar j = 0; j < W; j++) begin : g_col
      localparam bit LOW_Q   = (i < H) && (j < H);
      localparam bit HIGH_Q  = (i >= H) && (j >= H);
      localparam bit FULL_FL = ((i < W-1) && (j == W-1)) || ((i == W-1) && (j < W-1));
      localparam bit LO_FL   = ((i < H-1) && (j == H-1)) || ((i == H-1) && (j < H-1));
      localparam bit HI_FL   = ((i >= H) && (i < W-1) && (j == W-1)) ||
                               ((i == W-1) && (j >= H) && (j < W-1));
      logic keepBit;
      logic flipBit;
      always_comb begin
        keepBit = !strobes.gateCross || LOW_Q || HIGH_Q;
        flipBit = (strobes.fullInv && FULL_FL) || (strobes.halfInv && (LO_FL || HI_FL));
        ppBits[i][j] = keepBit & ((opA[j] & opB[i]) ^ flipBit);
      end
    end
  end

  // cross-quadrant bits stay silent in split mode
  always_comb begin
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        if (strobes.gateCross && ((i < H) != (j < H)))
          AST_CROSS_ZERO : assert (ppBits[i][j] == 1'b0); // R4
      end
    end
  end

endmodule

// File: rtl/twin_mul_reduce.sv
module twin_mul_reduce
  import twin_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0][W-1:0] ppBits,
  input  mulStrobes_t         strobes,
  output logic [2*W-1:0]      prod
);

  localparam int H  = W / 2;
  localparam int SW = 2 * W + 1;
  localparam logic [SW-1:0] ONE_WIDE   = {{(SW-1){1'b0}}, 1'b1};
  localparam logic [SW-1:0] HALF_CONST = (ONE_WIDE << H) | (ONE_WIDE << (W + H));
  localparam logic [SW-1:0] FULL_CONST = ONE_WIDE << W;
  localparam logic [2*W-1:0] TOP_BIT   = {1'b1, {(2*W-1){1'b0}}};
  localparam logic [2*W-1:0] MID_BIT   = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic [SW-1:0]  sumAcc;
  logic [2*W-1:0] outMask;

  always_comb begin
    sumAcc = strobes.halfConst ? HALF_CONST : '0;
    if (strobes.fullConst) sumAcc = sumAcc + FULL_CONST;
    for (int i = 0; i < W; i++) begin
      sumAcc = sumAcc + ({{(W+1){1'b0}}, ppBits[i]} << i);
    end
    outMask = TOP_BIT | (strobes.midOutInv ? MID_BIT : '0);
    prod    = sumAcc[2*W-1:0] ^ outMask;
  end

  // the biased array sum never spills past the product width
  always_comb begin
    AST_NO_CARRY_OUT : assert (sumAcc[SW-1] == 1'b0); // R1
  end

endmodule

// File: rtl/twin_bw_mul.sv
module twin_bw_mul
  import twin_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           twin,
  output logic [2*W-1:0] p
);

  localparam int H = W / 2;

  mulStrobes_t         strobes;
  logic [W-1:0][W-1:0] ppBits;

  twin_mul_ctrl u_ctrl (
    .twin    (twin),
    .strobes (strobes)
  );

  twin_mul_pparray #(.W(W)) u_pparray (
    .opA     (a),
    .opB     (b),
    .strobes (strobes),
    .ppBits  (ppBits)
  );

  twin_mul_reduce #(.W(W)) u_reduce (
    .ppBits  (ppBits),
    .strobes (strobes),
    .prod    (p)
  );

  // port-level product checks per mode
  logic signed [2*W-1:0] fullRef;
  logic signed [W-1:0]   loRef;
  logic signed [W-1:0]   hiRef;

  always_comb begin
    fullRef = $signed(a) * $signed(b);
    loRef   = $signed(a[H-1:0]) * $signed(b[H-1:0]);
    hiRef   = $signed(a[W-1:H]) * $signed(b[W-1:H]);
    if (!twin) begin
      AST_FULL_PRODUCT : assert ($signed(p) == fullRef); // R1
    end else begin
      AST_LOW_PRODUCT  : assert ($signed(p[W-1:0]) == loRef); // R2
      AST_HIGH_PRODUCT : assert ($signed(p[2*W-1:W]) == hiRef); // R3
    end
  end

endmodule

// File: tb/twin_bw_mul_tb.sv
module twin_bw_mul_tb;

  logic        clk = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic        twin = 1'b0;
  logic [15:0] p;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twin_bw_mul u_dut (
    .a    (a),
    .b    (b),
    .twin (twin),
    .p    (p)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h twin=%0d actual=%h expected=%h", req, a, b, twin, act, exp);
    end
  endtask

  function automatic logic [15:0] fullProd(input logic [7:0] x, input logic [7:0] y);
    int r;
    r = int'($signed(x)) * int'($signed(y));
    return r[15:0];
  endfunction

  function automatic logic [7:0] nibProd(input logic [3:0] x, input logic [3:0] y);
    int r;
    r = int'($signed(x)) * int'($signed(y));
    return r[7:0];
  endfunction

  // apply at falling edge, sample before the next rising edge
  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic m);
    @(negedge clk);
    a = x; b = y; twin = m;
    #2;
  endtask

  initial begin
    logic [7:0] loRef;
    // R1: full-mode exhaustive sweep
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        apply(8'(ai), 8'(bi), 1'b0);
        check("R1", p, fullProd(8'(ai), 8'(bi)));
      end
    end
    // R2, R3: split-mode exhaustive sweep
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        apply(8'(ai), 8'(bi), 1'b1);
        check("R2", {8'h00, p[7:0]}, {8'h00, nibProd(a[3:0], b[3:0])});
        check("R3", {8'h00, p[15:8]}, {8'h00, nibProd(a[7:4], b[7:4])});
      end
    end
    // R4: low byte fixed while high nibbles cycle, and the reverse
    apply(8'h09, 8'h0F, 1'b1);
    loRef = p[7:0];
    for (int h = 0; h < 256; h++) begin
      apply({h[3:0], 4'h9}, {h[7:4], 4'hF}, 1'b1);
      check("R4", {8'h00, p[7:0]}, {8'h00, loRef});
    end
    apply(8'hB0, 8'h80, 1'b1);
    loRef = p[15:8];
    for (int l = 0; l < 256; l++) begin
      apply({4'hB, l[3:0]}, {4'h8, l[7:4]}, 1'b1);
      check("R4", {8'h00, p[15:8]}, {8'h00, loRef});
    end
    // R5: full-mode extremes
    apply(8'h80, 8'h80, 1'b0); check("R5", p, 16'h4000);
    apply(8'h80, 8'h7F, 1'b0); check("R5", p, 16'hC080);
    apply(8'h7F, 8'h7F, 1'b0); check("R5", p, 16'h3F01);
    // R6: split-mode extremes
    apply(8'h88, 8'h88, 1'b1); check("R6", p, 16'h4040);
    apply(8'h88, 8'h77, 1'b1); check("R6", p, 16'hC8C8);
    apply(8'hFF, 8'hFF, 1'b1); check("R6", p, 16'h0101);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule